// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a synchronous SRAM that takes a new read or write command on every clock edge and never needs an idle cycle between them. Commands are registered on the rising edge. Read data reaches an output register two edges after its command. Write data is taken from the data-in bus two edges after its command. Because the write data arrives late, the write address and byte selects travel down a two-stage pipeline. A one-entry write buffer then holds the last write until it is committed to the array. Reads compare against that buffer and merge any pending bytes, so every read returns the newest data.

Commands are either a load, which takes a fresh address and op, or an advance, which continues the last loaded op. An advance steps a 2-bit burst counter over the low two address bits, in linear or interleaved order. A clock-enable input freezes the whole block. Three chip selects, two active high and one active low, gate every load. The bidirectional data bus is split into `din`, `dout` and `dout_oe`. The driver enable is low during write data phases and deselected cycles.

Top module: `zt_sram`

## Requirements
- R1: After reset, `dout_oe` is 0, `dout` is 0 and every word of the array reads as zero.
- R2: For a read command accepted at enabled edge k, `dout` holds the word and `dout_oe` is 1 after enabled edge k+2.
- R3: For a write command accepted at enabled edge k, `din` is sampled at enabled edge k+2. Byte i (bits i*BYTE_W upward) is written only when `byte_we[i]` was 1 in the command cycle. An active-high `wr_en` selects a write and 0 selects a read.
- R4: Reads and writes mix freely on consecutive enabled edges. A read returns the most recent data written to its address, including a write whose data has been sampled but not yet committed, merged byte by byte.
- R5: A load (`adv_ld`=0) is accepted only when `sel_a`=1, `sel_b`=1 and `sel_n`=0. Otherwise it is a deselect: nothing is written and `dout_oe` is 0 at its data phase.
- R6: `dout_oe` is 0 after the edge that samples write data.
- R7: While `clk_en` is 0, no command or data is captured, the array is unchanged, and `dout` and `dout_oe` hold their values.
- R8: With `burst_xor`=0, the n-th advance after a load at address A targets the upper bits of A with low bits (A[1:0]+n) mod 4.
- R9: With `burst_xor`=1, the n-th advance after a load at address A targets the upper bits of A with low bits A[1:0] XOR (n mod 4).
- R10: An advance repeats the read/write type of the last load and takes fresh `byte_we`. An advance after a deselect load is itself a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| clk_en | input | 1 | 1 lets the edge act, 0 freezes the block |
| adv_ld | input | 1 | 1 advances the burst, 0 loads a new command |
| burst_xor | input | 1 | 0 linear burst order, 1 interleaved |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_n | input | 1 | Chip select, active low |
| wr_en | input | 1 | 1 write, 0 read (on loads) |
| byte_we | input | BYTES | Per-byte write selects |
| addr | input | ADDR_W | Word address (on loads) |
| din | input | BYTES*BYTE_W | Write data, sampled two edges after the command |
| dout | output | BYTES*BYTE_W | Registered read data |
| dout_oe | output | 1 | Data driver enable |

## Verification
On every cycle the assertions check the output register and the enable. Stalls must hold `dout` and `dout_oe`, and a read in the last stage must raise the enable while a write there must drop it. A failed chip-select load must leave the first stage empty. An advance must keep the upper address bits of the word before it. Whether the right data comes back can only be shown by the bench's scenarios. Those scenarios cover write-then-read on adjacent edges through the write buffer, partial byte merges, bursts in both orders, and stalls placed inside these sequences. The bench compares them against a memory model on every clock.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clk_en,
  input  logic                      adv_ld,
  input  logic                      burst_xor,
  input  logic                      sel_a,
  input  logic                      sel_b,
  input  logic                      sel_n,
  input  logic                      wr_en,
  input  logic [BYTES-1:0]          byte_we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [BYTES*BYTE_W-1:0]   din,
  output logic [BYTES*BYTE_W-1:0]   dout,
  output logic                      dout_oe
);
  localparam int DATA_W = BYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              sel_ok;
  logic [ADDR_W-1:0] bst_base;
  logic [1:0]        bst_cnt, cnt_nx, low_nx;
  logic              bst_live, bst_wr;

  logic              cmd_v, cmd_w;
  logic [ADDR_W-1:0] cmd_a;

  logic              s1_v, s1_w, s2_v, s2_w;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [BYTES-1:0]  s1_be, s2_be;

  logic              wb_v;
  logic [ADDR_W-1:0] wb_a;
  logic [DATA_W-1:0] wb_d;
  logic [BYTES-1:0]  wb_be;

  logic [DATA_W-1:0] rd_raw, rd_fwd;
  logic              wb_hit;

  assign sel_ok = sel_a & sel_b & ~sel_n;
  assign cnt_nx = bst_cnt + 2'd1;
  assign low_nx = burst_xor ? (bst_base[1:0] ^ cnt_nx) : (bst_base[1:0] + cnt_nx);

  assign cmd_v = adv_ld ? bst_live : sel_ok;
  assign cmd_w = adv_ld ? bst_wr   : wr_en;
  assign cmd_a = adv_ld ? {bst_base[ADDR_W-1:2], low_nx} : addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst_base <= '0;
      bst_cnt  <= '0;
      bst_live <= 1'b0;
      bst_wr   <= 1'b0;
    end else if (clk_en) begin
      if (!adv_ld) begin
        bst_base <= addr;
        bst_cnt  <= '0;
        bst_live <= sel_ok;
        bst_wr   <= wr_en;
      end else if (bst_live) begin
        bst_cnt  <= cnt_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_w <= 1'b0; s1_a <= '0; s1_be <= '0;
      s2_v <= 1'b0; s2_w <= 1'b0; s2_a <= '0; s2_be <= '0;
    end else if (clk_en) begin
      s1_v  <= cmd_v;
      s1_w  <= cmd_w;
      s1_a  <= cmd_a;
      s1_be <= byte_we;
      s2_v  <= s1_v;
      s2_w  <= s1_w;
      s2_a  <= s1_a;
      s2_be <= s1_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_v  <= 1'b0;
      wb_a  <= '0;
      wb_d  <= '0;
      wb_be <= '0;
    end else if (clk_en) begin
      wb_v  <= s2_v & s2_w;
      wb_a  <= s2_a;
      wb_d  <= din;
      wb_be <= s2_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (clk_en && wb_v) begin
      for (int i = 0; i < BYTES; i++)
        if (wb_be[i]) mem[wb_a][i*BYTE_W +: BYTE_W] <= wb_d[i*BYTE_W +: BYTE_W];
    end
  end

  assign rd_raw = mem[s2_a];
  assign wb_hit = wb_v && (wb_a == s2_a);

  for (genvar g = 0; g < BYTES; g++) begin : g_fwd
    assign rd_fwd[g*BYTE_W +: BYTE_W] = (wb_hit && wb_be[g]) ? wb_d[g*BYTE_W +: BYTE_W]
                                                             : rd_raw[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else if (clk_en) begin
      dout_oe <= s2_v & ~s2_w;
      if (s2_v && !s2_w) dout <= rd_fwd;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(dout) && $stable(dout_oe)); // R7
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && s2_v && !s2_w |=> dout_oe); // R2
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && s2_v && s2_w |=> !dout_oe); // R6
  AST_DESELECT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !adv_ld && !(sel_a && sel_b && !sel_n) |=> !s1_v); // R5
  AST_BURST_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && adv_ld && s1_v |=> s1_v && (s1_a[ADDR_W-1:2] == $past(s1_a[ADDR_W-1:2]))); // R8
endmodule

// File: tb/zt_sram_bench.sv
module zt_sram_bench;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b0, adv_ld = 1'b0, burst_xor = 1'b0;
  logic sel_a = 1'b0, sel_b = 1'b0, sel_n = 1'b1, wr_en = 1'b0;
  logic [NB-1:0] byte_we = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_oe;

  always #2 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) u_zt_sram (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv_ld(adv_ld), .burst_xor(burst_xor),
    .sel_a(sel_a), .sel_b(sel_b), .sel_n(sel_n), .wr_en(wr_en), .byte_we(byte_we),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe));

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [DW-1:0] ref_mem [1 << AW];
  bit pv[2], pw[2];
  int pa[2];
  logic [NB-1:0] pbe[2];
  bit live = 0, live_wr = 0;
  int up = 0, start = 0, nadv = 0;
  logic [DW-1:0] exp_d = '0;
  bit exp_oe = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit en, input bit adv, input bit xo, input bit a, input bit b,
                      input bit n, input bit we, input logic [NB-1:0] be, input int ad,
                      input string tag);
    bit cv, cw;
    int ca;
    clk_en = en; adv_ld = adv; burst_xor = xo; sel_a = a; sel_b = b; sel_n = n;
    wr_en = we; byte_we = be; addr = ad[AW-1:0];
    din = {$urandom, $urandom};
    @(posedge clk);
    if (en) begin
      if (pv[1]) begin
        if (pw[1]) begin
          for (int i = 0; i < NB; i++)
            if (pbe[1][i]) ref_mem[pa[1]][i*BW +: BW] = din[i*BW +: BW];
        end else exp_d = ref_mem[pa[1]];
      end
      exp_oe = pv[1] && !pw[1];
      cv = 0; cw = 0; ca = 0;
      if (adv) begin
        if (live) begin
          nadv++;
          cv = 1; cw = live_wr;
          ca = up * 4 + (xo ? (start ^ (nadv % 4)) : ((start + nadv) % 4));
        end
      end else if (a && b && !n) begin
        live = 1; live_wr = we; up = ad / 4; start = ad % 4; nadv = 0;
        cv = 1; cw = we; ca = ad;
      end else live = 0;
      pv[1] = pv[0]; pw[1] = pw[0]; pa[1] = pa[0]; pbe[1] = pbe[0];
      pv[0] = cv;   pw[0] = cw;   pa[0] = ca;   pbe[0] = be;
    end
    @(negedge clk);
    check(dout_oe == exp_oe, tag, "dout_oe", DW'(dout_oe), DW'(exp_oe));
    if (exp_oe) check(dout == exp_d, tag, "dout", dout, exp_d);
  endtask

  task automatic rd(input int ad, input string tag);
    step(1, 0, 0, 1, 1, 0, 0, '0, ad, tag);
  endtask
  task automatic wr(input int ad, input logic [NB-1:0] be, input string tag);
    step(1, 0, 0, 1, 1, 0, 1, be, ad, tag);
  endtask
  task automatic idle(input int k, input string tag);
    for (int i = 0; i < k; i++) step(1, 0, 0, 0, 1, 0, 0, '0, 0, tag);
  endtask

  task automatic mix(input int k, input int amax, input bit stalls, input bit sels,
                     input bit bursts, input string tag);
    for (int i = 0; i < k; i++) begin
      bit en, adv, sa, sb, sn;
      en  = stalls ? ($urandom_range(0, 3) != 0) : 1'b1;
      adv = bursts ? $urandom_range(0, 1) : 1'b0;
      sa = 1; sb = 1; sn = 0;
      if (sels) begin sa = ($urandom_range(0, 3) != 0); sb = ($urandom_range(0, 3) != 0); sn = ($urandom_range(0, 3) == 0); end
      step(en, adv, $urandom_range(0, 1), sa, sb, sn, $urandom_range(0, 1),
           NB'($urandom), $urandom_range(0, amax), tag);
    end
  endtask

  initial begin
    for (int w = 0; w < (1 << AW); w++) ref_mem[w] = '0;
    for (int s = 0; s < 2; s++) begin pv[s] = 0; pw[s] = 0; pa[s] = 0; pbe[s] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dout_oe == 1'b0, "R1", "reset dout_oe", DW'(dout_oe), '0);
    check(dout == '0, "R1", "reset dout", dout, '0);
    for (int w = 0; w < (1 << AW); w++) rd(w, "R1");
    idle(2, "R1");
    // R2 and R3: single write, latency, partial byte update
    wr(5, 4'b1111, "R3"); idle(3, "R3");
    wr(5, 4'b0101, "R3"); idle(3, "R3");
    rd(5, "R2"); idle(2, "R2");
    // R4: back-to-back hazards through the pending write
    wr(9, 4'b1111, "R4"); rd(9, "R4"); wr(9, 4'b0010, "R4"); rd(9, "R4"); rd(9, "R4");
    wr(9, 4'b1000, "R4"); wr(10, 4'b1111, "R4"); rd(9, "R4"); rd(10, "R4"); idle(2, "R4");
    mix(600, 7, 0, 0, 0, "R4");
    // R5: chip select combinations
    step(1, 0, 0, 0, 1, 0, 1, 4'b1111, 3, "R5");
    step(1, 0, 0, 1, 0, 0, 1, 4'b1111, 3, "R5");
    step(1, 0, 0, 1, 1, 1, 1, 4'b1111, 3, "R5");
    idle(2, "R5"); rd(3, "R5"); idle(2, "R5");
    mix(300, 7, 0, 1, 0, "R5");
    // R6: dense write traffic keeps the driver off
    for (int i = 0; i < 20; i++) wr(i, NB'($urandom), "R6");
    idle(2, "R6");
    // R7: stalls inside sequences
    wr(12, 4'b1111, "R7");
    step(0, 0, 0, 1, 1, 0, 1, 4'b1111, 12, "R7");
    step(0, 0, 0, 1, 1, 0, 1, 4'b1111, 13, "R7");
    rd(12, "R7"); step(0, 0, 0, 1, 1, 0, 0, '0, 0, "R7");
    idle(3, "R7");
    mix(600, 7, 1, 0, 0, "R7");
    // R8 linear and R9 interleaved bursts
    for (int s = 0; s < 4; s++) begin
      wr(16 + s, 4'b1111, "R8");
      for (int k = 0; k < 5; k++) step(1, 1, 0, 0, 0, 1, 1, 4'b1111, 0, "R8");
      rd(16 + s, "R8");
      for (int k = 0; k < 5; k++) step(1, 1, 0, 0, 0, 1, 0, '0, 0, "R8");
    end
    for (int s = 0; s < 4; s++) begin
      wr(24 + s, 4'b1111, "R9");
      for (int k = 0; k < 5; k++) step(1, 1, 1, 0, 0, 1, 1, 4'b1111, 0, "R9");
      rd(24 + s, "R9");
      for (int k = 0; k < 5; k++) step(1, 1, 1, 0, 0, 1, 0, '0, 0, "R9");
    end
    idle(2, "R9");
    // R10: advance after deselect, op type carried, fresh byte selects
    step(1, 0, 0, 0, 0, 1, 1, 4'b1111, 32, "R10");
    for (int k = 0; k < 3; k++) step(1, 1, 0, 1, 1, 0, 1, 4'b1111, 0, "R10");
    wr(36, 4'b0001, "R10");
    step(1, 1, 0, 0, 0, 1, 0, 4'b0110, 0, "R10");
    rd(36, "R10"); step(1, 1, 0, 0, 0, 1, 1, 4'b1111, 0, "R10");
    idle(2, "R10");
    mix(800, 15, 1, 1, 1, "R10");
    idle(3, "R10");
    for (int w = 0; w < (1 << AW); w++) rd(w, "R4");
    idle(2, "R4");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule